// File: doc/BRIEF.md
# Periodic Sensor Sampling Sequencer

This block decides when each of up to four temperature sensor channels, all sharing one ADC, gets sampled. It fetches the raw ADC word through a simple request/acknowledge read port, checks the word for validity and scales it to a 12-bit monitor value. Each accepted sample leaves the block as a one-cycle pulse that carries a channel tag. Timing rests on a base tick of `period_unit` × 256 clock cycles. The sensor interval is the number of base ticks that pass before a channel's measurement begins. The filter interval is the number of base ticks between the samples that make up one measurement. A cycle-counted poll interval sets the spacing of retries after an invalid read.

The controller is a single state machine. Its states are ST_IDLE, ST_SENSE_WAIT, ST_FILT_WAIT, ST_RD_VALID, ST_RD_VOLT, ST_POLL_WAIT and ST_EMIT, and its transitions are:

- ST_IDLE → ST_SENSE_WAIT when any enable bit is set. The next channel is chosen at this point.
- ST_SENSE_WAIT and ST_FILT_WAIT → ST_RD_VALID when the tick timer expires.
- ST_RD_VALID, on acknowledge:
  - → ST_POLL_WAIT if the word is invalid.
  - → ST_RD_VOLT if separate addresses are selected.
  - → ST_EMIT otherwise.
- ST_RD_VOLT → ST_EMIT on acknowledge.
- ST_POLL_WAIT → ST_RD_VALID when the poll timer expires.
- ST_EMIT:
  - → ST_FILT_WAIT while the measurement still needs samples.
  - → ST_IDLE when the measurement is complete.

Top module: `sensor_sample_seq`

## Requirements
- R1: After reset `rd_req` and `smp_valid` are low. The first channel serviced is the lowest-numbered enabled channel.
- R2: While `chan_en` is all zero the block stays idle and never raises `rd_req`.
- R3: Bit i of `chan_en` enables channel i. Enabled channels are serviced in ascending order, wrapping from 3 back to 0, and disabled channels are skipped.
- R4: The first read of a measurement is requested sense_ivl × period_unit × 256 cycles after the channel is chosen, with up to 4 cycles of pipeline slack. A `period_unit` of 0 acts as 1.
- R5: One measurement holds `burst_len` samples (0 acts as 1). Between a sample's output pulse and the next read of the same measurement, filt_ivl × period_unit × 256 cycles pass, with up to 4 cycles of slack.
- R6: A read is valid when bit `valid_pos` of `rd_data` equals `valid_pol`. A polarity of 1 means active high and 0 means active low.
- R7: An invalid read issues no sample. The read is retried `poll_ivl` cycles after its acknowledge, with up to 4 cycles of slack.
- R8: `smp_data` equals the low 12 bits of the voltage word shifted right by `volt_shift`.
- R9: With `split_addr` = 0 every read uses `valid_addr`, and the voltage comes from the same word. With `split_addr` = 1 a valid read at `valid_addr` is followed by a read at `volt_addr`, and that second word supplies the voltage.
- R10: Once raised, `rd_req` stays high with a stable `rd_addr` until `rd_ack`.
- R11: `smp_valid` is a one-cycle pulse, and `smp_chan` names the channel the sample belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 4 | Channel enable bits, bit i for channel i |
| period_unit | input | 10 | Base tick length in units of 256 cycles |
| sense_ivl | input | 10 | Base ticks before each measurement |
| filt_ivl | input | 10 | Base ticks between samples of one measurement |
| burst_len | input | 4 | Samples per measurement, 0 means 1 |
| poll_ivl | input | 32 | Cycles between a failed read and its retry |
| valid_pos | input | 5 | Bit position of the valid flag in a raw word |
| valid_pol | input | 1 | 1: flag active high, 0: active low |
| volt_shift | input | 5 | Right shift applied to the voltage word |
| split_addr | input | 1 | 1: separate voltage address, 0: shared word |
| valid_addr | input | 32 | Address read for validity (and voltage when shared) |
| volt_addr | input | 32 | Address read for voltage in split mode |
| rd_req | output | 1 | Read request to the ADC port |
| rd_addr | output | 32 | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | 32 | Raw word returned by the ADC port |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 2 | Channel tag of the sample |
| smp_data | output | 12 | Scaled sample value |

## Verification
Some internal faults show up immediately at the ports:
- A corrupted round-robin pointer gives a wrong `smp_chan` on the very next sample.
- A wrong mode decision gives a wrong `rd_addr` on the following request.
- A qualifier fault gives a wrong `smp_data`, or a missing or extra pulse, within one read.

Timer faults appear as request spacing outside the stated windows. They show up within one sensor, filter or poll interval after the channel is chosen. A state machine stuck in a wait state shows as samples that never arrive.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENSE_WAIT,
        ST_FILT_WAIT,
        ST_RD_VALID,
        ST_RD_VOLT,
        ST_POLL_WAIT,
        ST_EMIT
    } seq_state_e;

endpackage

// File: rtl/sseq_rr_pick.sv
module sseq_rr_pick #(
    parameter int N_CHAN = 4,
    parameter int CH_W   = $clog2(N_CHAN)
) (
    input  logic [N_CHAN-1:0] en,
    input  logic [CH_W-1:0]   last,
    output logic              any,
    output logic [CH_W-1:0]   pick
);

    // Scan from the farthest candidate to the nearest so the nearest wins.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int off = N_CHAN; off >= 1; off--) begin
            if (en[(int'(last) + off) % N_CHAN]) begin
                any  = 1'b1;
                pick = CH_W'((int'(last) + off) % N_CHAN);
            end
        end
    end

    always_comb begin
        if (any) begin
            AST_PICK_ENABLED: assert (en[pick]) else $error("picked a disabled channel"); // R3
        end
    end

endmodule

// File: rtl/sseq_tick_timer.sv
module sseq_tick_timer #(
    parameter int UNIT_W = 10,
    parameter int SCALE  = 256,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [UNIT_W-1:0] unit,
    input  logic [CNT_W-1:0]  count,
    output logic              done
);

    localparam int PRE_W = UNIT_W + $clog2(SCALE) + 1;

    logic [UNIT_W-1:0] unit_q;
    logic [CNT_W-1:0]  target_q;
    logic [CNT_W-1:0]  ticks_q;
    logic [PRE_W-1:0]  cyc_q;
    logic [UNIT_W-1:0] unit_eff;
    logic [PRE_W-1:0]  lim;

    always_comb begin
        unit_eff = (unit_q == '0) ? UNIT_W'(1) : unit_q;
        lim      = PRE_W'(unit_eff) * PRE_W'(SCALE) - PRE_W'(1);
        done     = (ticks_q == target_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_q   <= '0;
            target_q <= '0;
            ticks_q  <= '0;
            cyc_q    <= '0;
        end else if (start) begin
            unit_q   <= unit;
            target_q <= count;
            ticks_q  <= '0;
            cyc_q    <= '0;
        end else if (ticks_q != target_q) begin
            if (cyc_q == lim) begin
                cyc_q   <= '0;
                ticks_q <= ticks_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    AST_TICKS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (ticks_q <= target_q)) else $error("tick count overran"); // R4

endmodule

// File: rtl/sseq_poll_timer.sv
module sseq_poll_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] ivl,
    output logic         done
);

    logic [W-1:0] ivl_q;
    logic [W-1:0] cnt_q;

    assign done = (cnt_q == ivl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            ivl_q <= ivl;
            cnt_q <= '0;
        end else if (cnt_q != ivl_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POLL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q <= ivl_q) |=> (cnt_q <= ivl_q)) else $error("poll counter wrapped"); // R7

endmodule

// File: rtl/sseq_sample_qual.sv
module sseq_sample_qual #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5,
    parameter int OUT_W  = 12
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [POS_W-1:0]  pos,
    input  logic              pol,
    input  logic [POS_W-1:0]  shift,
    output logic              ok,
    output logic [OUT_W-1:0]  volt
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        ok      = (raw[pos] == pol);
        shifted = raw >> shift;
        volt    = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/sensor_sample_seq.sv
module sensor_sample_seq
    import sseq_pkg::*;
#(
    parameter int N_CHAN     = 4,
    parameter int UNIT_W     = 10,
    parameter int TICK_SCALE = 256,
    parameter int IVL_W      = 10,
    parameter int BURST_W    = 4,
    parameter int POLL_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int POS_W      = 5,
    parameter int OUT_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CHAN-1:0]         chan_en,
    input  logic [UNIT_W-1:0]         period_unit,
    input  logic [IVL_W-1:0]          sense_ivl,
    input  logic [IVL_W-1:0]          filt_ivl,
    input  logic [BURST_W-1:0]        burst_len,
    input  logic [POLL_W-1:0]         poll_ivl,
    input  logic [POS_W-1:0]          valid_pos,
    input  logic                      valid_pol,
    input  logic [POS_W-1:0]          volt_shift,
    input  logic                      split_addr,
    input  logic [ADDR_W-1:0]         valid_addr,
    input  logic [ADDR_W-1:0]         volt_addr,
    output logic                      rd_req,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      rd_ack,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      smp_valid,
    output logic [$clog2(N_CHAN)-1:0] smp_chan,
    output logic [OUT_W-1:0]          smp_data
);

    localparam int CH_W = $clog2(N_CHAN);

    seq_state_e         state_q, state_d;
    logic [CH_W-1:0]    cur_q, last_q, pick;
    logic               any_en;
    logic [BURST_W-1:0] idx_q;
    logic [BURST_W-1:0] burst_eff;
    logic               meas_more;
    logic               tmr_start, tmr_done;
    logic [IVL_W-1:0]   tmr_count;
    logic               poll_start, poll_done;
    logic               qual_ok;
    logic [OUT_W-1:0]   qual_volt;
    logic [OUT_W-1:0]   data_q;

    sseq_rr_pick #(.N_CHAN(N_CHAN), .CH_W(CH_W)) u_pick (
        .en   (chan_en),
        .last (last_q),
        .any  (any_en),
        .pick (pick)
    );

    sseq_tick_timer #(.UNIT_W(UNIT_W), .SCALE(TICK_SCALE), .CNT_W(IVL_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .unit  (period_unit),
        .count (tmr_count),
        .done  (tmr_done)
    );

    sseq_poll_timer #(.W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .start (poll_start),
        .ivl   (poll_ivl),
        .done  (poll_done)
    );

    sseq_sample_qual #(.DATA_W(DATA_W), .POS_W(POS_W), .OUT_W(OUT_W)) u_qual (
        .raw   (rd_data),
        .pos   (valid_pos),
        .pol   (valid_pol),
        .shift (volt_shift),
        .ok    (qual_ok),
        .volt  (qual_volt)
    );

    always_comb begin
        burst_eff = (burst_len == '0) ? BURST_W'(1) : burst_len;
        meas_more = ({1'b0, idx_q} + 1'b1) < {1'b0, burst_eff};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (any_en) state_d = ST_SENSE_WAIT;
            ST_SENSE_WAIT: if (tmr_done) state_d = ST_RD_VALID;
            ST_FILT_WAIT:  if (tmr_done) state_d = ST_RD_VALID;
            ST_RD_VALID: begin
                if (rd_ack) begin
                    if (!qual_ok)       state_d = ST_POLL_WAIT;
                    else if (split_addr) state_d = ST_RD_VOLT;
                    else                state_d = ST_EMIT;
                end
            end
            ST_RD_VOLT:    if (rd_ack) state_d = ST_EMIT;
            ST_POLL_WAIT:  if (poll_done) state_d = ST_RD_VALID;
            ST_EMIT:       state_d = meas_more ? ST_FILT_WAIT : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Outputs and timer controls
    always_comb begin
        rd_req     = (state_q == ST_RD_VALID) || (state_q == ST_RD_VOLT);
        rd_addr    = (state_q == ST_RD_VOLT) ? volt_addr : valid_addr;
        smp_valid  = (state_q == ST_EMIT);
        smp_chan   = cur_q;
        smp_data   = data_q;
        tmr_start  = ((state_q == ST_IDLE) && any_en) || ((state_q == ST_EMIT) && meas_more);
        tmr_count  = (state_q == ST_IDLE) ? sense_ivl : filt_ivl;
        poll_start = (state_q == ST_RD_VALID) && rd_ack && !qual_ok;
    end

    // Channel, sample index and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            last_q <= CH_W'(N_CHAN - 1);
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && any_en) begin
                cur_q  <= pick;
                last_q <= pick;
                idx_q  <= '0;
            end
            if (state_q == ST_EMIT) idx_q <= idx_q + 1'b1;
            if (state_q == ST_RD_VALID && rd_ack && qual_ok && !split_addr) data_q <= qual_volt;
            if (state_q == ST_RD_VOLT && rd_ack) data_q <= qual_volt;
        end
    end

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && chan_en == '0) |=> (state_q == ST_IDLE && !rd_req)) else $error("left idle with no enables"); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))) else $error("request dropped before ack"); // R10

    AST_SMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid) else $error("sample strobe longer than one cycle"); // R11

    AST_RETRY_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_VALID && rd_ack && !qual_ok) |=> (state_q == ST_POLL_WAIT && !smp_valid)) else $error("invalid read not retried"); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rd_req && !smp_valid)) else $error("activity right after reset"); // R1

endmodule

// File: tb/sensor_sample_seq_tb_top.sv
`timescale 1ns/1ps
module sensor_sample_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  chan_en;
    logic [9:0]  period_unit, sense_ivl, filt_ivl;
    logic [3:0]  burst_len;
    logic [31:0] poll_ivl;
    logic [4:0]  valid_pos, volt_shift;
    logic        valid_pol, split_addr;
    logic [31:0] valid_addr, volt_addr;
    logic        rd_req, rd_ack;
    logic [31:0] rd_addr, rd_data;
    logic        smp_valid;
    logic [1:0]  smp_chan;
    logic [11:0] smp_data;

    always #10 clk = ~clk;

    sensor_sample_seq dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .period_unit(period_unit),
        .sense_ivl(sense_ivl), .filt_ivl(filt_ivl), .burst_len(burst_len),
        .poll_ivl(poll_ivl), .valid_pos(valid_pos), .valid_pol(valid_pol),
        .volt_shift(volt_shift), .split_addr(split_addr), .valid_addr(valid_addr),
        .volt_addr(volt_addr), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rsp_q[$];
    logic [31:0] addr_q[$];
    logic [13:0] exp_q[$];
    logic [31:0] dflt_word = 32'h0;
    int lat = 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic push_exp(input int ch, input int d);
        exp_q.push_back({ch[1:0], d[11:0]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        chan_en = 4'b0;
        rsp_q.delete();
        addr_q.delete();
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_drain(input string tag);
        int w;
        w = 0;
        while (exp_q.size() > 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(exp_q.size() == 0, tag, "pending samples", exp_q.size(), 0);
        repeat (300) @(negedge clk);
    endtask

    // ADC read-port model: answers requests after 'lat' cycles
    initial begin : adc_model
        logic [31:0] a;
        logic [31:0] ea;
        bit aborted;
        rd_ack = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && rd_req === 1'b1 && !rd_ack) begin
                a = rd_addr;
                aborted = 1'b0;
                for (int k = 1; k < lat; k++) begin
                    @(negedge clk);
                    if (rst_n !== 1'b1) begin
                        aborted = 1'b1;
                        break;
                    end
                    chk(rd_req === 1'b1 && rd_addr === a, "R10", "request held", rd_addr, a);
                end
                if (!aborted) begin
                    if (addr_q.size() > 0) begin
                        ea = addr_q.pop_front();
                        chk(a == ea, "R9", "read address", a, ea);
                    end
                    rd_data = (rsp_q.size() > 0) ? rsp_q.pop_front() : dflt_word;
                    rd_ack = 1'b1;
                    @(negedge clk);
                    rd_ack = 1'b0;
                end
            end else begin
                rd_ack = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    initial begin : monitor
        logic prev;
        logic [13:0] e;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n !== 1'b1) begin
                prev = 1'b0;
            end else begin
                if (smp_valid) begin
                    chk(!prev, "R11", "strobe width", 2, 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7", "unexpected sample", {smp_chan, smp_data}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(smp_chan == e[13:12], "R3", "channel tag", smp_chan, e[13:12]);
                        chk(smp_data == e[11:0], "R8", "sample value", smp_data, e[11:0]);
                    end
                end
                prev = smp_valid;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : driver
        int cnt;
        period_unit = 10'd1; sense_ivl = 10'd1; filt_ivl = 10'd1; burst_len = 4'd1;
        poll_ivl = 32'd20; valid_pos = 5'd16; valid_pol = 1'b1; volt_shift = 5'd4;
        split_addr = 1'b0; valid_addr = 32'h1000; volt_addr = 32'h2000;
        do_reset();

        // R1: quiet after reset
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(rd_req == 1'b0, "R1", "rd_req after reset", rd_req, 0);
        chk(smp_valid == 1'b0, "R1", "smp_valid after reset", smp_valid, 0);

        // R2: no enables, no reads
        cnt = 0;
        repeat (3000) begin
            @(negedge clk); #1;
            if (rd_req) cnt++;
        end
        chk(cnt == 0, "R2", "reads while idle", cnt, 0);

        // Shared word, active-high flag at bit 16, shift 4, burst 2
        do_reset();
        sense_ivl = 10'd3; filt_ivl = 10'd1; burst_len = 4'd2; period_unit = 10'd1;
        dflt_word = 32'h0;
        rsp_q = '{32'h0001_1234, 32'h0001_0FFF, 32'h0001_ABCD, 32'h0001_0010};
        addr_q = '{32'h1000, 32'h1000, 32'h1000, 32'h1000};
        push_exp(0, 12'h123); push_exp(0, 12'h0FF); push_exp(2, 12'hABC); push_exp(2, 12'h001); // R1 R6 R8
        rst_n = 1'b1;
        @(negedge clk);
        chan_en = 4'b0101;
        cnt = 0;
        do begin @(negedge clk); #1; cnt++; end while (!rd_req && cnt < 5000);
        chk(cnt >= 768 && cnt <= 772, "R4", "sense delay", cnt, 768);
        do begin @(negedge clk); #1; end while (!smp_valid);
        cnt = 0;
        do begin @(negedge clk); #1; cnt++; end while (!rd_req && cnt < 5000);
        chk(cnt >= 256 && cnt <= 260, "R5", "filter gap", cnt, 256);
        wait_drain("R5");

        // Active-low flag at bit 3, no shift, burst 0 as 1, invalid retry, slow ack
        do_reset();
        sense_ivl = 10'd1; burst_len = 4'd0; valid_pos = 5'd3; valid_pol = 1'b0;
        volt_shift = 5'd0; poll_ivl = 32'd40; lat = 3; dflt_word = 32'h8;
        rsp_q = '{32'h0001_2A50, 32'h0000_0778, 32'hFFFF_F3C0, 32'h0000_0124};
        addr_q = '{32'h1000, 32'h1000, 32'h1000, 32'h1000};
        push_exp(1, 12'hA50); push_exp(3, 12'h3C0); push_exp(1, 12'h124); // R3 wrap, R6 low
        rst_n = 1'b1;
        @(negedge clk);
        chan_en = 4'b1010;
        do begin @(negedge clk); #1; end while (!(rd_ack && rd_data == 32'h778));
        cnt = 0;
        do begin @(negedge clk); #1; cnt++; end while (!(rd_req && !rd_ack) && cnt < 5000);
        chk(cnt >= 40 && cnt <= 44, "R7", "retry gap", cnt, 40);
        wait_drain("R6");

        // Split addresses, period unit 2, invalid then valid flag at bit 0, shift 8
        do_reset();
        period_unit = 10'd2; sense_ivl = 10'd1; burst_len = 4'd1; valid_pos = 5'd0;
        valid_pol = 1'b1; volt_shift = 5'd8; split_addr = 1'b1; poll_ivl = 32'd20;
        lat = 2; dflt_word = 32'h0;
        rsp_q = '{32'h0, 32'h1, 32'h00AB_C123, 32'h1, 32'h0};
        addr_q = '{32'h1000, 32'h1000, 32'h2000, 32'h1000, 32'h2000};
        push_exp(3, 12'hBC1); push_exp(3, 12'h000); // R9
        rst_n = 1'b1;
        @(negedge clk);
        chan_en = 4'b1000;
        cnt = 0;
        do begin @(negedge clk); #1; cnt++; end while (!rd_req && cnt < 5000);
        chk(cnt >= 512 && cnt <= 516, "R4", "sense delay with unit 2", cnt, 512);
        wait_drain("R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule